// File: doc/BRIEF.md
# Configuration Header Clock-Ratio Detector

This block watches a stream of 32-bit configuration words as they pass on their way to the fabric. It does not alter or forward the stream. It picks two flags out of the image header at fixed word positions. One flag says whether the image is encrypted and the other says whether it is compressed.

The block combines those two flags with the configuration bus width, which is 16 or 32 bits. From them it forms the 2-bit code for the ratio between configuration clocks and data words. The loader logic can apply that code without software reading the header.

A word is taken when `valid_i` is high and an image is open. A word flagged with `sof_i` opens an image and becomes word 0. A word flagged with `eof_i` closes the image. If an image closes before its header is complete, the block raises an error instead of a ratio.

Top module: `hdr_ratio_detect`

## Requirements
- R1: While `rst_ni` is low, and until the first image completes, `ratio_o`, `ratio_valid_o` and `hdr_err_o` are all 0.
- R2: The image is taken as encrypted when bits [3:2] of word index 69 are not both zero.
- R3: The image is taken as compressed when bit 1 of word index 229 is 0.
- R4: The width is latched from `wide_i` on the start word, where 1 means 32-bit and 0 means 16-bit. The ratio code is derived as follows:
  - With neither flag set, the code is 0 (x1).
  - For a compressed image, the code is 2 (x4) at 16-bit width and 3 (x8) at 32-bit width.
  - For an encrypted-only image, the code is 1 (x2) at 16-bit width and 2 (x4) at 32-bit width.
- R5: `ratio_valid_o` rises in the cycle after word 229 is taken. It holds, together with `ratio_o`, until the next start word is taken. `ratio_o` reads 0 whenever `ratio_valid_o` is low.
- R6: A start word that is taken clears `ratio_valid_o`, `ratio_o` and `hdr_err_o` in the next cycle, and restarts word counting at 0, even in the middle of an image.
- R7: An end word taken at an index below 229 sets `hdr_err_o` in the next cycle. `hdr_err_o` then holds until the next start word, and `ratio_valid_o` stays 0.
- R8: The word index saturates past 229, so words after index 229, however many there are, do not change the flags or the ratio.
- R9: Words presented while no image is open are ignored. This covers words before the first start word and words after an end word.
- R10: Cycles with `valid_i` low do not advance the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A configuration word is present |
| sof_i | input | 1 | The present word is the first word of an image |
| eof_i | input | 1 | The present word is the last word of an image |
| wide_i | input | 1 | Bus width: 1 for 32-bit, 0 for 16-bit (sampled on the start word) |
| data_i | input | 32 | Configuration word |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_valid_o | output | 1 | `ratio_o` holds the ratio for the current image |
| hdr_err_o | output | 1 | The image ended before its header was complete |

## Verification
The hardest case to reach is saturation of the word index. Reaching it needs an image several hundred words long. The words after index 229 must carry the opposite flag patterns, so that a counter which wrapped or kept matching would visibly change the ratio.

The bench drives 600-word images in which every word past 229 inverts both flag fields. It also places a second start word in the middle of an image. Finally, it interleaves idle cycles and words sent outside any image, showing that neither moves the index.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // base x2 (encrypted) or x4 (compressed), doubled on the wide bus
  function automatic ratio_e ratio_code(input logic wide, input logic enc, input logic cmp);
    logic [1:0] base;
    if (!enc && !cmp) return RATIO_X1;
    base = cmp ? 2'd2 : 2'd1;
    return ratio_e'(base + {1'b0, wide});
  endfunction
endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int unsigned LAST_IDX = 229,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             take_o,
  output logic [CNT_W-1:0] idx_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign take_o = valid_i && (sof_i || busy_q);
  assign idx_o  = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take_o) begin
      busy_q <= !eof_i;
      // stop one past the last header word
      if (idx_o <= CNT_W'(LAST_IDX)) cnt_q <= idx_o + 1'b1;
      else                           cnt_q <= idx_o;
    end
  end
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned ENC_MSB = 3,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              sof_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              wide_i,
  output logic              enc_o,
  output logic              wide_o,
  output logic              cmp_hit_o,
  output logic              cmp_now_o
);
  logic enc_q, wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (take_i) begin
      if (sof_i) begin
        enc_q  <= 1'b0;
        wide_q <= wide_i;
      end
      if (idx_i == CNT_W'(ENC_IDX)) enc_q <= |data_i[ENC_MSB:ENC_LSB];
    end
  end

  assign enc_o     = enc_q;
  assign wide_o    = wide_q;
  assign cmp_hit_o = take_i && (idx_i == CNT_W'(CMP_IDX));
  assign cmp_now_o = !data_i[CMP_BIT];
endmodule

// File: rtl/hdr_ratio_encode.sv
module hdr_ratio_encode
  import hdr_ratio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       short_i,
  input  logic       enc_i,
  input  logic       cmp_i,
  input  logic       wide_i,
  output logic [1:0] ratio_o,
  output logic       valid_o,
  output logic       err_o
);
  ratio_e ratio_q;
  logic   valid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_X1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start_i) begin
        ratio_q <= RATIO_X1;
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (done_i) begin
        ratio_q <= ratio_code(wide_i, enc_i, cmp_i);
        valid_q <= 1'b1;
      end
      if (short_i) err_q <= 1'b1;
    end
  end

  assign ratio_o = ratio_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned ENC_MSB = 3,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [1:0]        ratio_o,
  output logic              ratio_valid_o,
  output logic              hdr_err_o
);
  localparam int unsigned CNT_W = $clog2(CMP_IDX + 2);

  logic             take, enc, wide, cmp_hit, cmp_now, start, short_end;
  logic [CNT_W-1:0] idx;

  hdr_word_counter #(.LAST_IDX(CMP_IDX), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .valid_i, .sof_i, .eof_i,
    .take_o(take), .idx_o(idx)
  );

  hdr_flag_capture #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .ENC_IDX(ENC_IDX), .ENC_LSB(ENC_LSB),
    .ENC_MSB(ENC_MSB), .CMP_IDX(CMP_IDX), .CMP_BIT(CMP_BIT)
  ) i_cap (
    .clk_i, .rst_ni, .take_i(take), .sof_i, .idx_i(idx), .data_i, .wide_i,
    .enc_o(enc), .wide_o(wide), .cmp_hit_o(cmp_hit), .cmp_now_o(cmp_now)
  );

  assign start     = take && sof_i;
  assign short_end = take && eof_i && (idx < CNT_W'(CMP_IDX));

  hdr_ratio_encode i_enc (
    .clk_i, .rst_ni, .start_i(start), .done_i(cmp_hit), .short_i(short_end),
    .enc_i(enc), .cmp_i(cmp_now), .wide_i(wide),
    .ratio_o, .valid_o(ratio_valid_o), .err_o(hdr_err_o)
  );
endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       sof_i,
  input logic [1:0] ratio_o,
  input logic       ratio_valid_o,
  input logic       hdr_err_o
);
  // R5
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_valid_o && !(valid_i && sof_i) |=> ratio_valid_o);
  // R5
  ratio_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_valid_o |-> ratio_o == 2'd0);
  // R6
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sof_i |=> !ratio_valid_o);
  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o && !(valid_i && sof_i) |=> hdr_err_o);
  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_err_o && ratio_valid_o));
endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
  .ratio_o(ratio_o), .ratio_valid_o(ratio_valid_o), .hdr_err_o(hdr_err_o)
);

// File: tb/test_hdr_ratio_detect.sv
module test_hdr_ratio_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0, wide_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  ratio_o;
  logic        ratio_valid_o, hdr_err_o;
  int          errs = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  hdr_ratio_detect i_hdr_ratio_detect (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(int k, logic [1:0] eb, logic cb);
    logic [31:0] w;
    w = (32'(k) * 32'h0100_0193) ^ 32'h5A5A_3C3C;
    if (k == 69) w[3:2] = eb;
    if (k == 229) w[1] = cb;
    if (k > 229) begin
      w[3:2] = ~eb;
      w[1]   = ~cb;
    end
    return w;
  endfunction

  function automatic int exp_code(bit w32, logic [1:0] eb, bit cb);
    bit enc = (eb != 2'b00);
    bit cmp = !cb;
    if (!enc && !cmp) return 0;
    return (cmp ? 2 : 1) + int'(w32);
  endfunction

  task automatic idle_in(bit pend);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
    if (pend) chk("R5 valid one cycle after word 229", int'(ratio_valid_o), 1);
  endtask

  task automatic run_image(int n, bit w32, logic [1:0] eb, bit cb, int gap, bit with_eof);
    bit pend = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_i);
        idle_in(pend);
        pend = 1'b0;
      end
      @(negedge clk_i);
      if (pend) chk("R5 valid one cycle after word 229", int'(ratio_valid_o), 1);
      pend = 1'b0;
      if (k == 229) chk("R5 not valid before word 229 taken", int'(ratio_valid_o), 0);
      valid_i = 1'b1;
      sof_i   = (k == 0);
      eof_i   = with_eof && (k == n - 1);
      wide_i  = (k == 0) ? w32 : !w32;
      data_i  = word_at(k, eb, cb);
      if (k == 229) pend = 1'b1;
    end
    @(negedge clk_i);
    idle_in(pend);
  endtask

  task automatic stray_words(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 1'b1; sof_i = 1'b0; eof_i = (k % 7 == 3);
      data_i  = (k % 2 == 0) ? 32'h0000_000C : 32'h0000_0000;
    end
    @(negedge clk_i);
    idle_in(1'b0);
  endtask

  task automatic expect_out(string tag, int r, int v, int e);
    chk({tag, " ratio"}, int'(ratio_o), r);
    chk({tag, " valid"}, int'(ratio_valid_o), v);
    chk({tag, " err"}, int'(hdr_err_o), e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    expect_out("R1 in reset", 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_out("R1 after reset", 0, 0, 0);

    stray_words(300);
    expect_out("R9 words before first start", 0, 0, 0);

    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 2; c++) begin
          run_image(230, w[0], e[1:0], c[0], 0, 1'b1);
          expect_out($sformatf("R2 R3 R4 w=%0d e=%0d c=%0d", w, e, c),
                     exp_code(w[0], e[1:0], c[0]), 1, 0);
        end

    for (int m = 0; m < 4; m++) begin
      run_image(600, m[0], {m[1], 1'b0}, m[0], 0, 1'b1);
      expect_out($sformatf("R8 long image m=%0d", m), exp_code(m[0], {m[1], 1'b0}, m[0]), 1, 0);
    end

    run_image(230, 1'b1, 2'b01, 1'b1, 2, 1'b1);
    expect_out("R10 gapped image", exp_code(1'b1, 2'b01, 1'b1), 1, 0);

    run_image(230, 1'b0, 2'b10, 1'b0, 0, 1'b0);
    repeat (5) @(negedge clk_i);
    expect_out("R5 hold without end", exp_code(1'b0, 2'b10, 1'b0), 1, 0);

    begin
      int lens[4] = '{1, 69, 70, 229};
      foreach (lens[i]) begin
        run_image(lens[i], 1'b1, 2'b11, 1'b0, 0, 1'b1);
        expect_out($sformatf("R6 R7 short image len=%0d", lens[i]), 0, 0, 1);
      end
    end

    stray_words(300);
    expect_out("R9 words after end", 0, 0, 1);

    run_image(230, 1'b0, 2'b00, 1'b1, 0, 1'b1);
    expect_out("R6 start clears error", 0, 1, 0);

    run_image(100, 1'b0, 2'b11, 1'b1, 0, 1'b0);
    run_image(230, 1'b1, 2'b00, 1'b0, 0, 1'b1);
    expect_out("R6 restart mid-image", exp_code(1'b1, 2'b00, 1'b0), 1, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog R1: actual=0 expected=1 (run did not end)");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule